// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs the external bus cycles of a 16-bit processor core on a bus that multiplexes the low address bits with data and carries a 20-bit address in total. The core presents a single-cycle request with direction, address, write data and a byte-high enable. The controller turns each request into a cycle of at least four clocks: address phase, strobe phase, ready sampling, and completion. It drives the address latch strobe, the active-low read, write, data-enable and status lines, and the transceiver direction line. Every pin group has its own output-enable so that the bus can be released.

Two ready inputs stretch a cycle. One is used directly at the ready-sampling edge. The other may change at any time, so it first passes through a flop synchronizer. An external master can ask for the bus through a hold input. The controller grants it only between cycles and floats every pin group while the grant lasts.

Reset produces a fixed pin sequence. In the first clock after reset is seen, the control, status and lock lines are driven to their inactive high levels while the address, data and direction lines float. For the rest of reset everything floats. The latch strobe and the hold acknowledge stay low throughout.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: With ready already true, a cycle takes exactly four clocks: `ale_o` high for one clock (T1), the selected strobe low for two clocks (T2, T3), then both strobes high with `done_o` high (T4).
- R2: When neither ready is true at the clock edge that ends T3 or a wait state, one more wait state follows with the strobe still low. With ready held false for n such edges, the strobe stays low for n+2 clocks.
- R3: `ardy_i` reaches the sequencer through a two-flop synchronizer. If it rises during T2 while `srdy_i` stays low, exactly one wait state is inserted.
- R4: `ale_o` is high only in T1. In T1, `ad_o` carries address bits 15:0 with `ad_oe_o` high. From T1 through T4, `ahi_o` carries address bits 19:16, `bhe_n_o` carries the inverted byte-high enable and `addr_oe_o` is high.
- R5: A write drives `dtr_o` high from T1 to T4, puts the write data on `ad_o` from T2 to T4 and pulls only `wr_n_o` low. A read drives `dtr_o` low, floats `ad_o` from T2 to T4 and pulls only `rd_n_o` low. `den_n_o` is low from T2 to T4.
- R6: Read data is taken from `ad_i` at the edge where ready is accepted and is held on `rdata_o` while `done_o` is high.
- R7: `sts_n_o` is 3'b101 for a read and 3'b110 for a write in T1 and T2. It is the passive code 3'b111 in every other driven state.
- R8: A hold request is granted only from idle or from T4. `hlda_o` rises the clock after such a state sees `hold_i` high and falls the clock after `hold_i` is seen low.
- R9: While `hlda_o` is high, every output-enable (`ad_oe_o`, `addr_oe_o`, `ctl_oe_o`, `dtr_oe_o`, `sts_oe_o`, `lock_oe_o`) is low.
- R10: In the first clock after reset is sampled high, `rd_n_o`, `wr_n_o`, `den_n_o` and `lock_n_o` are driven high and `sts_n_o` is driven to 3'b111. In that clock `ad_oe_o`, `addr_oe_o` and `dtr_oe_o` are low and `ale_o` and `hlda_o` are low.
- R11: In every further clock while reset stays high, all output-enables, `ale_o` and `hlda_o` are low. After release, the idle bus drives the control and status lines inactive and floats `ad_o`.
- R12: `req_ack_o` is high in the clock in which a request is accepted. That requires idle or T4 with `hold_i` low, so hold wins over a request arriving at the same boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Core requests a bus cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Cycle address |
| req_wdata_i | input | 16 | Write data |
| req_bhe_i | input | 1 | Byte-high enable (active high at the core) |
| req_ack_o | output | 1 | Request accepted this clock |
| done_o | output | 1 | Cycle in its final clock |
| rdata_o | output | 16 | Captured read data |
| ad_i | input | 16 | Multiplexed lines, input side |
| ad_o | output | 16 | Multiplexed lines, output side |
| ad_oe_o | output | 1 | Drive enable for the multiplexed lines |
| ahi_o | output | 4 | Upper address bits |
| bhe_n_o | output | 1 | Byte-high enable, active low |
| addr_oe_o | output | 1 | Drive enable for upper address and byte-high |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| den_n_o | output | 1 | Transceiver enable, active low |
| ctl_oe_o | output | 1 | Drive enable for read, write and data-enable |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| dtr_oe_o | output | 1 | Drive enable for the direction line |
| sts_n_o | output | 3 | Cycle status, active low |
| sts_oe_o | output | 1 | Drive enable for the status lines |
| lock_n_o | output | 1 | Bus lock, active low |
| lock_oe_o | output | 1 | Drive enable for the lock line |
| srdy_i | input | 1 | Ready, already synchronous |
| ardy_i | input | 1 | Ready, asynchronous |
| hold_i | input | 1 | External master requests the bus |
| hlda_o | output | 1 | Bus granted to the external master |

## Verification
The bench uses the default parameters: a 20-bit address over a 16-bit multiplexed field with a two-stage synchronizer. With these values the top of the address space (FFFFF, FFFF0) and address zero can be reached, and all four upper address bits are exercised through `ahi_o`. The fixed synchronizer depth means an asynchronous ready that rises in T2 must cost exactly one wait state, and the bench measures this. Stimulus covers zero, one and three wait states for both reads and writes, a hold raised mid-cycle and at idle, and a reset applied while the bus is held.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_T1,
        BS_T2,
        BS_T3,
        BS_TW,
        BS_T4,
        BS_HOLD
    } bus_state_e;

    localparam logic [2:0] STS_PASSIVE = 3'b111;
    localparam logic [2:0] STS_READ    = 3'b101;
    localparam logic [2:0] STS_WRITE   = 3'b110;

    function automatic logic [2:0] sts_for(input logic we);
        return we ? STS_WRITE : STS_READ;
    endfunction

    function automatic logic is_boundary(input bus_state_e st);
        return (st == BS_IDLE) || (st == BS_T4);
    endfunction

    function automatic logic is_sample(input bus_state_e st);
        return (st == BS_T3) || (st == BS_TW);
    endfunction

endpackage

// File: rtl/lbus_ready_sync.sv
module lbus_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES:0] chain;

    assign chain[0] = d_i;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g+1] <= 1'b0;
            else     chain[g+1] <= chain[g];
        end
    end

    assign q_o = chain[STAGES];
endmodule

// File: rtl/lbus_rst_seq.sv
module lbus_rst_seq (
    input  logic clk,
    input  logic rst,
    output logic drive_o,
    output logic float_o
);
    logic seen_q;
    logic held_q;

    always_ff @(posedge clk) begin
        seen_q <= rst;
        held_q <= seen_q;
    end

    assign drive_o = seen_q & ~held_q;
    assign float_o = seen_q & held_q;
endmodule

// File: rtl/lbus_cycle_fsm.sv
module lbus_cycle_fsm
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              req_bhe_i,
    input  logic              ready_i,
    input  logic              hold_i,
    input  logic [DATA_W-1:0] ad_i,
    output bus_state_e        state_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              bhe_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o
);
    typedef struct packed {
        logic              we;
        logic              bhe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cyc_req_t;

    bus_state_e        st_q, st_d;
    cyc_req_t          cur_q;
    logic [DATA_W-1:0] rdata_q;
    logic              take;

    always_comb begin
        take = is_boundary(st_q) && !hold_i && req_i;
        st_d = st_q;
        unique case (st_q)
            BS_IDLE, BS_T4: begin
                if (hold_i)     st_d = BS_HOLD;
                else if (req_i) st_d = BS_T1;
                else            st_d = BS_IDLE;
            end
            BS_T1:          st_d = BS_T2;
            BS_T2:          st_d = BS_T3;
            BS_T3, BS_TW:   st_d = ready_i ? BS_T4 : BS_TW;
            BS_HOLD:        st_d = hold_i ? BS_HOLD : BS_IDLE;
            default:        st_d = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= BS_IDLE;
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                cur_q.we    <= req_we_i;
                cur_q.bhe   <= req_bhe_i;
                cur_q.addr  <= req_addr_i;
                cur_q.wdata <= req_wdata_i;
            end
            if (is_sample(st_q) && ready_i && !cur_q.we)
                rdata_q <= ad_i;
        end
    end

    assign state_o = st_q;
    assign we_o    = cur_q.we;
    assign addr_o  = cur_q.addr;
    assign wdata_o = cur_q.wdata;
    assign bhe_o   = cur_q.bhe;
    assign rdata_o = rdata_q;
    assign ack_o   = take;
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
    import lbus_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic                     req_we_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic                     req_bhe_i,
    output logic                     req_ack_o,
    output logic                     done_o,
    output logic [DATA_W-1:0]        rdata_o,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] ahi_o,
    output logic                     bhe_n_o,
    output logic                     addr_oe_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic                     den_n_o,
    output logic                     ctl_oe_o,
    output logic                     dtr_o,
    output logic                     dtr_oe_o,
    output logic [2:0]               sts_n_o,
    output logic                     sts_oe_o,
    output logic                     lock_n_o,
    output logic                     lock_oe_o,
    input  logic                     srdy_i,
    input  logic                     ardy_i,
    input  logic                     hold_i,
    output logic                     hlda_o
);
    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_e        st;
    logic              cyc_we, cyc_bhe, ardy_s, ready, rst_drive, rst_float;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;

    lbus_ready_sync #(.STAGES(SYNC_STAGES)) u_ardy_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ardy_i),
        .q_o (ardy_s)
    );

    lbus_rst_seq u_rst_seq (
        .clk     (clk),
        .rst     (rst),
        .drive_o (rst_drive),
        .float_o (rst_float)
    );

    assign ready = srdy_i | ardy_s;

    lbus_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .req_bhe_i   (req_bhe_i),
        .ready_i     (ready),
        .hold_i      (hold_i),
        .ad_i        (ad_i),
        .state_o     (st),
        .we_o        (cyc_we),
        .addr_o      (cyc_addr),
        .wdata_o     (cyc_wdata),
        .bhe_o       (cyc_bhe),
        .rdata_o     (rdata_o),
        .ack_o       (req_ack_o)
    );

    assign done_o = (st == BS_T4);

    always_comb begin
        ad_o      = '0;
        ad_oe_o   = 1'b0;
        ahi_o     = '0;
        bhe_n_o   = 1'b1;
        addr_oe_o = 1'b0;
        ale_o     = 1'b0;
        rd_n_o    = 1'b1;
        wr_n_o    = 1'b1;
        den_n_o   = 1'b1;
        ctl_oe_o  = 1'b0;
        dtr_o     = 1'b1;
        dtr_oe_o  = 1'b0;
        sts_n_o   = STS_PASSIVE;
        sts_oe_o  = 1'b0;
        lock_n_o  = 1'b1;
        lock_oe_o = 1'b0;
        hlda_o    = 1'b0;

        unique case (st)
            BS_IDLE: begin
                ctl_oe_o  = 1'b1;
                sts_oe_o  = 1'b1;
                lock_oe_o = 1'b1;
                dtr_oe_o  = 1'b1;
            end
            BS_T1: begin
                ale_o     = 1'b1;
                ad_o      = cyc_addr[DATA_W-1:0];
                ad_oe_o   = 1'b1;
                ahi_o     = cyc_addr[ADDR_W-1:ADDR_W-HI_W];
                bhe_n_o   = ~cyc_bhe;
                addr_oe_o = 1'b1;
                ctl_oe_o  = 1'b1;
                sts_n_o   = sts_for(cyc_we);
                sts_oe_o  = 1'b1;
                lock_oe_o = 1'b1;
                dtr_o     = cyc_we;
                dtr_oe_o  = 1'b1;
            end
            BS_T2, BS_T3, BS_TW, BS_T4: begin
                ad_o      = cyc_wdata;
                ad_oe_o   = cyc_we;
                ahi_o     = cyc_addr[ADDR_W-1:ADDR_W-HI_W];
                bhe_n_o   = ~cyc_bhe;
                addr_oe_o = 1'b1;
                ctl_oe_o  = 1'b1;
                rd_n_o    = cyc_we || (st == BS_T4);
                wr_n_o    = !cyc_we || (st == BS_T4);
                den_n_o   = 1'b0;
                sts_n_o   = (st == BS_T2) ? sts_for(cyc_we) : STS_PASSIVE;
                sts_oe_o  = 1'b1;
                lock_oe_o = 1'b1;
                dtr_o     = cyc_we;
                dtr_oe_o  = 1'b1;
            end
            BS_HOLD: begin
                hlda_o = 1'b1;
            end
            default: ;
        endcase

        if (rst_drive || rst_float) begin
            ad_oe_o   = 1'b0;
            addr_oe_o = 1'b0;
            dtr_oe_o  = 1'b0;
            ale_o     = 1'b0;
            hlda_o    = 1'b0;
            rd_n_o    = 1'b1;
            wr_n_o    = 1'b1;
            den_n_o   = 1'b1;
            sts_n_o   = STS_PASSIVE;
            lock_n_o  = 1'b1;
            ctl_oe_o  = rst_drive;
            sts_oe_o  = rst_drive;
            lock_oe_o = rst_drive;
        end
    end
endmodule

// File: rtl/lbus_cycle_ctrl_chk.sv
module lbus_cycle_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ale_o,
    input logic       rd_n_o,
    input logic       wr_n_o,
    input logic       den_n_o,
    input logic       ctl_oe_o,
    input logic       ad_oe_o,
    input logic       addr_oe_o,
    input logic       dtr_oe_o,
    input logic [2:0] sts_n_o,
    input logic       sts_oe_o,
    input logic       lock_n_o,
    input logic       lock_oe_o,
    input logic       srdy_i,
    input logic       ardy_i,
    input logic       hlda_o
);
    logic armed;
    logic strobe;

    always_ff @(posedge clk) armed <= armed | ~rst;

    assign strobe = !(rd_n_o && wr_n_o);

    AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        ale_o |=> !ale_o); // R4

    AST_T2_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $past(ale_o) |-> (!rd_n_o ^ !wr_n_o)); // R1

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o)); // R5

    AST_STROBE_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n_o && wr_n_o) |=> strobe); // R1

    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe) && !srdy_i && !ardy_i && !$past(ardy_i)
         && !$past(ardy_i, 2)) |=> strobe); // R2

    AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda_o) |-> ($past(rd_n_o) && $past(wr_n_o) && !$past(ale_o))); // R8

    AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (rst)
        hlda_o |-> !(ad_oe_o || addr_oe_o || ctl_oe_o || dtr_oe_o
                     || sts_oe_o || lock_oe_o)); // R9

    AST_RST_DRIVE: assert property (@(posedge clk) disable iff (!armed)
        $rose(rst) |=> (ctl_oe_o && rd_n_o && wr_n_o && den_n_o && sts_oe_o
                        && (sts_n_o == 3'b111) && lock_oe_o && lock_n_o
                        && !ad_oe_o && !addr_oe_o && !dtr_oe_o
                        && !ale_o && !hlda_o)); // R10

    AST_RST_FLOAT: assert property (@(posedge clk) disable iff (!armed)
        (rst && $past(rst)) |=> !(ad_oe_o || addr_oe_o || ctl_oe_o || dtr_oe_o
                                  || sts_oe_o || lock_oe_o || ale_o || hlda_o)); // R11
endmodule

bind lbus_cycle_ctrl lbus_cycle_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .den_n_o   (den_n_o),
    .ctl_oe_o  (ctl_oe_o),
    .ad_oe_o   (ad_oe_o),
    .addr_oe_o (addr_oe_o),
    .dtr_oe_o  (dtr_oe_o),
    .sts_n_o   (sts_n_o),
    .sts_oe_o  (sts_oe_o),
    .lock_n_o  (lock_n_o),
    .lock_oe_o (lock_oe_o),
    .srdy_i    (srdy_i),
    .ardy_i    (ardy_i),
    .hlda_o    (hlda_o)
);

// File: tb/lbus_cycle_ctrl_tb.sv
module lbus_cycle_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_i, req_we_i, req_bhe_i;
    logic [19:0] req_addr_i;
    logic [15:0] req_wdata_i;
    logic        req_ack_o, done_o;
    logic [15:0] rdata_o, ad_i, ad_o;
    logic        ad_oe_o;
    logic [3:0]  ahi_o;
    logic        bhe_n_o, addr_oe_o, ale_o, rd_n_o, wr_n_o, den_n_o, ctl_oe_o;
    logic        dtr_o, dtr_oe_o;
    logic [2:0]  sts_n_o;
    logic        sts_oe_o, lock_n_o, lock_oe_o;
    logic        srdy_i, ardy_i, hold_i, hlda_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    lbus_cycle_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_i(req_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .req_bhe_i(req_bhe_i),
        .req_ack_o(req_ack_o), .done_o(done_o), .rdata_o(rdata_o),
        .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .ahi_o(ahi_o), .bhe_n_o(bhe_n_o), .addr_oe_o(addr_oe_o),
        .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .den_n_o(den_n_o),
        .ctl_oe_o(ctl_oe_o), .dtr_o(dtr_o), .dtr_oe_o(dtr_oe_o),
        .sts_n_o(sts_n_o), .sts_oe_o(sts_oe_o),
        .lock_n_o(lock_n_o), .lock_oe_o(lock_oe_o),
        .srdy_i(srdy_i), .ardy_i(ardy_i), .hold_i(hold_i), .hlda_o(hlda_o)
    );

    // entry: {we, waits[1:0], bhe, addr[19:0], data[15:0]}
    localparam int NVEC = 6;
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 1'b1, 20'hFFFF0, 16'h1234},
        {1'b1, 2'd0, 1'b0, 20'h00004, 16'hA5A5},
        {1'b0, 2'd1, 1'b1, 20'h3C0DE, 16'h0F0F},
        {1'b1, 2'd3, 1'b1, 20'hFFFFF, 16'hFFFF},
        {1'b0, 2'd3, 1'b0, 20'h00000, 16'h0000},
        {1'b1, 2'd1, 1'b1, 20'h81234, 16'h5A00}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] oe_bits();
        return {26'd0, ad_oe_o, addr_oe_o, ctl_oe_o, dtr_oe_o, sts_oe_o, lock_oe_o};
    endfunction

    task automatic run_cycle(input logic we, input int waits, input logic bhe,
                             input logic [19:0] addr, input logic [15:0] data,
                             input bit use_async);
        int k;
        logic [2:0] code;
        code = we ? 3'b110 : 3'b101;
        @(negedge clk);
        req_i = 1'b1; req_we_i = we; req_addr_i = addr;
        req_wdata_i = data; req_bhe_i = bhe; ad_i = data;
        srdy_i = use_async ? 1'b0 : (waits == 0);
        #1 check(req_ack_o == 1'b1, "R12 ack", {31'd0, req_ack_o}, 1);
        @(negedge clk);                         // T1
        req_i = 1'b0;
        check(ale_o == 1'b1, "R4 ale in T1", {31'd0, ale_o}, 1);
        check(ad_oe_o && ad_o == addr[15:0], "R4 low address", {16'd0, ad_o}, {16'd0, addr[15:0]});
        check(addr_oe_o && ahi_o == addr[19:16] && bhe_n_o == ~bhe, "R4 upper address",
              {27'd0, bhe_n_o, ahi_o}, {27'd0, ~bhe, addr[19:16]});
        check(sts_oe_o && sts_n_o == code, "R7 status T1", {29'd0, sts_n_o}, {29'd0, code});
        check(dtr_oe_o && dtr_o == we, "R5 direction", {31'd0, dtr_o}, {31'd0, we});
        @(negedge clk);                         // T2
        if (use_async) ardy_i = 1'b1;
        check(we ? (!wr_n_o && rd_n_o) : (!rd_n_o && wr_n_o), "R5 strobe select",
              {30'd0, rd_n_o, wr_n_o}, we ? 32'd2 : 32'd1);
        check(den_n_o == 1'b0 && ale_o == 1'b0, "R5 den in T2", {30'd0, den_n_o, ale_o}, 0);
        check(sts_n_o == code, "R7 status T2", {29'd0, sts_n_o}, {29'd0, code});
        check(ad_oe_o == we && (!we || ad_o == data), "R5 data phase",
              {15'd0, ad_oe_o, ad_o}, {15'd0, we, we ? data : ad_o});
        @(negedge clk);                         // T3
        k = 0;
        while (!(rd_n_o && wr_n_o) && k < 8) begin
            if (!use_async) srdy_i = (k >= waits);
            if (k == 0) check(sts_n_o == 3'b111, "R7 passive in T3", {29'd0, sts_n_o}, 7);
            @(negedge clk);
            k++;
        end
        if (use_async)
            check(k == 2, "R3 async one wait", k, 2);
        else if (waits == 0)
            check(k == 1, "R1 four clock cycle", k, 1);
        else
            check(k == waits + 1, "R2 wait states", k, waits + 1);
        check(done_o == 1'b1, "R6 done in T4", {31'd0, done_o}, 1);
        if (!we) check(rdata_o == data, "R6 read data", {16'd0, rdata_o}, {16'd0, data});
        else     check(ad_oe_o && ad_o == data, "R5 data held T4", {16'd0, ad_o}, {16'd0, data});
        check(addr_oe_o == 1'b1 && den_n_o == 1'b0, "R4 address held T4",
              {30'd0, addr_oe_o, den_n_o}, 2);
        ardy_i = 1'b0;
        srdy_i = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_i = 1'b0; req_we_i = 1'b0; req_bhe_i = 1'b0;
        req_addr_i = '0; req_wdata_i = '0; ad_i = '0;
        srdy_i = 1'b1; ardy_i = 1'b0; hold_i = 1'b0;
        repeat (4) @(negedge clk);
        check(oe_bits() == 0 && !ale_o && !hlda_o, "R11 float in reset", oe_bits(), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ctl_oe_o && sts_oe_o && rd_n_o && wr_n_o && !ad_oe_o && sts_n_o == 3'b111,
              "R11 idle after release", oe_bits(), 32'h0F);

        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VEC[i][39], int'(VEC[i][38:37]), VEC[i][36],
                      VEC[i][35:16], VEC[i][15:0], 1'b0);
            @(negedge clk);
        end

        run_cycle(1'b0, 1, 1'b1, 20'h5AA55, 16'hC3C3, 1'b1);
        @(negedge clk);

        // hold raised mid-cycle: grant waits for the boundary
        @(negedge clk);
        req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 20'h12345; req_wdata_i = 16'hBEEF;
        @(negedge clk);                         // T1
        req_i = 1'b0; hold_i = 1'b1;
        @(negedge clk);                         // T2
        check(!hlda_o && !wr_n_o, "R8 no grant in T2", {30'd0, hlda_o, wr_n_o}, 0);
        @(negedge clk);                         // T3
        check(!hlda_o && !wr_n_o, "R8 no grant in T3", {30'd0, hlda_o, wr_n_o}, 0);
        @(negedge clk);                         // T4
        check(!hlda_o && done_o, "R8 no grant in T4", {30'd0, hlda_o, done_o}, 1);
        @(negedge clk);
        check(hlda_o == 1'b1, "R8 grant after T4", {31'd0, hlda_o}, 1);
        check(oe_bits() == 0, "R9 floated in hold", oe_bits(), 0);
        hold_i = 1'b0;
        @(negedge clk);
        check(!hlda_o && ctl_oe_o, "R8 release", {30'd0, hlda_o, ctl_oe_o}, 1);

        // hold and request together at idle: hold wins
        req_i = 1'b1; req_we_i = 1'b0; hold_i = 1'b1;
        #1 check(req_ack_o == 1'b0, "R12 hold priority", {31'd0, req_ack_o}, 0);
        @(negedge clk);
        req_i = 1'b0;
        check(hlda_o && !ale_o, "R8 grant at idle", {30'd0, hlda_o, ale_o}, 2);
        check(oe_bits() == 0, "R9 floated at idle grant", oe_bits(), 0);

        // reset while the bus is held
        rst = 1'b1;
        @(negedge clk);
        check(ctl_oe_o && rd_n_o && wr_n_o && den_n_o && lock_oe_o && lock_n_o
              && sts_oe_o && sts_n_o == 3'b111, "R10 drive high",
              {24'd0, ctl_oe_o, rd_n_o, wr_n_o, den_n_o, lock_oe_o, lock_n_o, sts_oe_o,
               sts_n_o == 3'b111}, 32'hFF);
        check(!ad_oe_o && !addr_oe_o && !dtr_oe_o && !ale_o && !hlda_o, "R10 float others",
              {27'd0, ad_oe_o, addr_oe_o, dtr_oe_o, ale_o, hlda_o}, 0);
        @(negedge clk);
        check(oe_bits() == 0 && !ale_o && !hlda_o, "R11 float after drive", oe_bits(), 0);
        @(negedge clk);
        check(oe_bits() == 0 && !hlda_o, "R11 float held", oe_bits(), 0);
        hold_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(ctl_oe_o && !ad_oe_o && !hlda_o, "R11 idle after second release",
              oe_bits(), 32'h0F);

        run_cycle(1'b0, 0, 1'b1, 20'hFFFF0, 16'h7E7E, 1'b0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule